// File: doc/BRIEF.md
# Multicast Membership Flush Engine

This block walks an address table from its first index to its last in a single pass and removes a chosen set of switch ports from every multicast address entry it finds. Software or a neighbouring control block supplies a port set to remove, a VLAN ID, and a flag that widens the sweep to every VLAN, then pulses a start strobe. The engine reads each entry through a synchronous single-port table interface, classifies it, and writes it back only when the entry actually changes.

Entries that are not multicast addresses, that belong to another VLAN (unless the sweep covers all VLANs), that carry the pinned ("super") attribute, or that hold the all-ones broadcast MAC are left as they are. When a qualifying entry loses its last member port it is returned to the free pool. When the sweep ends the engine pulses a completion strobe for one cycle.

The controller is a four-state machine. IDLE waits for start. READ issues the table read for the current index. EVAL looks at the returned entry, issues the write if one is needed, and then moves to READ for the next index or to DONE after the last index. DONE raises the completion strobe and returns to IDLE. The transitions are IDLE→READ on start, READ→EVAL always, EVAL→READ while indices remain, EVAL→DONE at the last index, and DONE→IDLE always.

Top module: `mc_flush_engine`

## Requirements
- R1: A start pulse seen in IDLE captures the port set, VLAN ID and all-VLAN flag. Busy rises on the next cycle, and table indices 0 to DEPTH-1 are then read in ascending order.
- R2: Only entries whose type field (bits 61:60) is 1 (address) or 3 (VLAN address) and whose multicast bit 40 is set are candidates. No other entry is ever written.
- R3: With the all-VLAN flag low, a candidate is touched only if its VLAN ID in bits 59:48 equals the captured VID. With the flag high the VLAN ID is ignored.
- R4: A candidate with the super bit (bit 65) set is not written.
- R5: A candidate whose MAC field (bits 47:0) is all ones is not written.
- R6: A candidate whose member mask (NPORTS bits starting at bit 66) shares no bit with the captured port set is not written.
- R7: If the member mask minus the port set is non-zero, the entry is written back with that reduced mask and all other bits unchanged.
- R8: If the member mask minus the port set is zero, the entry is written back with its type field set to 0 (free) and all other bits unchanged.
- R9: Done is high for exactly one cycle, 2*DEPTH+1 cycles after the start pulse is sampled. Busy is low while done is high.
- R10: A start pulse while busy is ignored: the sweep's port set, VID and length are unchanged.
- R11: Out of reset, busy, done, the read enable and the write enable are all low.
- R12: Each index takes two cycles. The read is issued in the first, and any write goes to the same index in the second. Read and write are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (sampled in IDLE only) |
| flush_ports | input | NPORTS | Ports to remove from multicast entries |
| flush_vid | input | 12 | VLAN ID to restrict the sweep to |
| flush_all_vlans | input | 1 | 1: ignore VLAN ID |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion strobe |
| tbl_addr | output | IDX_W | Table index for read or write |
| tbl_rd_en | output | 1 | Table read enable (data valid next cycle) |
| tbl_rdata | input | ENTRY_W | Table read data |
| tbl_wr_en | output | 1 | Table write enable |
| tbl_wdata | output | ENTRY_W | Table write data |

## Verification
The bench fills the table with one entry per skip rule: a unicast address, a VLAN-only entry, a free slot, a super entry, a broadcast entry, an entry in a different VLAN and a mask with no overlap. A design that ignores any of these rules issues a write the scoreboard did not expect. Two sweeps in sequence take one entry through mask reduction and then through freeing, which catches designs that free too early or corrupt bits outside the mask. A stray start in mid-sweep with a wider port set would alter results or restart the index if it were honoured. A sweep with an empty port set must produce no write at all.

// File: rtl/mc_flush_pkg.sv
package mc_flush_pkg;

    localparam int TYPE_LO   = 60;
    localparam int VID_LO    = 48;
    localparam int VID_W     = 12;
    localparam int MCAST_BIT = 40;
    localparam int SUPER_BIT = 65;
    localparam int MASK_LO   = 66;
    localparam int MAC_W     = 48;

    localparam logic [1:0] TYPE_FREE  = 2'd0;
    localparam logic [1:0] TYPE_ADDR  = 2'd1;
    localparam logic [1:0] TYPE_VADDR = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_DONE
    } flush_state_t;

endpackage

// File: rtl/mc_flush_seq.sv
module mc_flush_seq
    import mc_flush_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int DEPTH  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPORTS-1:0] req_ports,
    input  logic [VID_W-1:0]  req_vid,
    input  logic              req_all,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic              eval,
    output logic [IDX_W-1:0]  idx,
    output logic [NPORTS-1:0] cur_ports,
    output logic [VID_W-1:0]  cur_vid,
    output logic              cur_all
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    flush_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_READ;
            ST_READ: state_d = ST_EVAL;
            ST_EVAL: state_d = (idx == LAST_IDX) ? ST_DONE : ST_READ;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx       <= '0;
            cur_ports <= '0;
            cur_vid   <= '0;
            cur_all   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                idx       <= '0;
                cur_ports <= req_ports;
                cur_vid   <= req_vid;
                cur_all   <= req_all;
            end else if (state_q == ST_EVAL && idx != LAST_IDX) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        busy  = 1'b0;
        done  = 1'b0;
        rd_en = 1'b0;
        eval  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin busy = 1'b1; rd_en = 1'b1; end
            ST_EVAL: begin busy = 1'b1; eval  = 1'b1; end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cur_ports) && $stable(cur_vid) && $stable(cur_all)));

    p_read_then_eval_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (eval && $stable(idx)));

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> (busy && idx == '0));

endmodule

// File: rtl/mc_flush_decide.sv
module mc_flush_decide
    import mc_flush_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int ENTRY_W = MASK_LO + NPORTS
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [NPORTS-1:0]  ports,
    input  logic [VID_W-1:0]   vid,
    input  logic               all_vlans,
    output logic               modify,
    output logic [ENTRY_W-1:0] new_entry
);

    logic [1:0]        etype;
    logic [NPORTS-1:0] members, remain;
    logic              is_cand, vid_ok, exempt;

    always_comb begin
        etype   = entry[TYPE_LO +: 2];
        members = entry[MASK_LO +: NPORTS];
        remain  = members & ~ports;
        is_cand = (etype == TYPE_ADDR || etype == TYPE_VADDR) && entry[MCAST_BIT];
        vid_ok  = all_vlans || (entry[VID_LO +: VID_W] == vid);
        exempt  = entry[SUPER_BIT] || (entry[MAC_W-1:0] == {MAC_W{1'b1}});
        modify  = is_cand && vid_ok && !exempt && ((members & ports) != '0);

        new_entry = entry;
        if (remain == '0)
            new_entry[TYPE_LO +: 2] = TYPE_FREE;
        else
            new_entry[MASK_LO +: NPORTS] = remain;
    end

endmodule

// File: rtl/mc_flush_engine.sv
module mc_flush_engine
    import mc_flush_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int DEPTH  = 16,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ENTRY_W = MASK_LO + NPORTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NPORTS-1:0]  flush_ports,
    input  logic [VID_W-1:0]   flush_vid,
    input  logic               flush_all_vlans,
    output logic               busy,
    output logic               done,
    output logic [IDX_W-1:0]   tbl_addr,
    output logic               tbl_rd_en,
    input  logic [ENTRY_W-1:0] tbl_rdata,
    output logic               tbl_wr_en,
    output logic [ENTRY_W-1:0] tbl_wdata
);

    logic              eval, modify;
    logic [NPORTS-1:0] cur_ports;
    logic [VID_W-1:0]  cur_vid;
    logic              cur_all;

    mc_flush_seq #(.NPORTS(NPORTS), .DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_ports (flush_ports),
        .req_vid   (flush_vid),
        .req_all   (flush_all_vlans),
        .busy      (busy),
        .done      (done),
        .rd_en     (tbl_rd_en),
        .eval      (eval),
        .idx       (tbl_addr),
        .cur_ports (cur_ports),
        .cur_vid   (cur_vid),
        .cur_all   (cur_all)
    );

    mc_flush_decide #(.NPORTS(NPORTS)) u_dec (
        .entry     (tbl_rdata),
        .ports     (cur_ports),
        .vid       (cur_vid),
        .all_vlans (cur_all),
        .modify    (modify),
        .new_entry (tbl_wdata)
    );

    assign tbl_wr_en = eval && modify;

    p_no_rw_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbl_rd_en && tbl_wr_en));

    p_wr_skips_super_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> !tbl_rdata[SUPER_BIT]);

    p_wr_clears_ports_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> ((tbl_wdata[MASK_LO +: NPORTS] & cur_ports) == '0
                       || tbl_wdata[TYPE_LO +: 2] == TYPE_FREE));

    p_wr_only_mcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> (tbl_rdata[MCAST_BIT] && tbl_rdata[TYPE_LO]));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tbl_rd_en && !tbl_wr_en));

endmodule

// File: tb/sim_mc_flush_engine.sv
`timescale 1ns/1ps
module sim_mc_flush_engine;

    localparam int NP    = 3;
    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH);
    localparam int EW    = 66 + NP;
    localparam logic [47:0] MC_MAC = 48'h01005E000001;
    localparam logic [47:0] UC_MAC = 48'h001122334455;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NP-1:0] fports = '0;
    logic [11:0]   fvid = '0;
    logic          fall = 1'b0;
    logic          busy, done, rd_en, wr_en;
    logic [IW-1:0] addr;
    logic [EW-1:0] rdata, wdata;

    int checks = 0;
    int fails  = 0;

    logic [EW-1:0] mem [DEPTH];
    logic [EW-1:0] expt [DEPTH];
    logic [IW-1:0] q_addr [$];
    logic [EW-1:0] q_data [$];

    always #4 clk = ~clk;

    mc_flush_engine #(.NPORTS(NP), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .flush_ports(fports), .flush_vid(fvid), .flush_all_vlans(fall),
        .busy(busy), .done(done),
        .tbl_addr(addr), .tbl_rd_en(rd_en), .tbl_rdata(rdata),
        .tbl_wr_en(wr_en), .tbl_wdata(wdata)
    );

    always_ff @(posedge clk) begin
        if (rd_en) rdata <= mem[addr];
        if (wr_en) mem[addr] <= wdata;
    end

    function automatic logic [EW-1:0] mk(logic [1:0] t, logic [11:0] v, logic sup,
                                         logic [47:0] mac, logic [NP-1:0] m);
        logic [EW-1:0] e;
        e = '0;
        e[61:60] = t;
        e[59:48] = v;
        e[47:0]  = mac;
        e[65]    = sup;
        e[66 +: NP] = m;
        return e;
    endfunction

    task automatic check(string req, logic ok, logic [EW-1:0] act, logic [EW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every write must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (q_addr.size() == 0) begin
                check("R2/R3/R4/R5/R6 unexpected write", 1'b0, {{(EW-IW){1'b0}}, addr}, '0);
            end else begin
                logic [IW-1:0] ea;
                logic [EW-1:0] ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                check("R7/R8/R12 write addr", addr == ea, {{(EW-IW){1'b0}}, addr}, {{(EW-IW){1'b0}}, ea});
                check("R7/R8 write data", wdata == ed, wdata, ed);
            end
        end
    end

    // Driver: predict writes from the requirements, then run one sweep.
    task automatic sweep(logic [NP-1:0] p, logic [11:0] v, logic a, bit inject);
        int n;
        for (int i = 0; i < DEPTH; i++) begin
            logic [EW-1:0] e;
            logic [NP-1:0] m;
            e = expt[i];
            m = e[66 +: NP];
            if ((e[61:60] == 2'd1 || e[61:60] == 2'd3) && e[40] && (a || e[59:48] == v)
                && !e[65] && e[47:0] != 48'hFFFF_FFFF_FFFF && (m & p) != '0) begin
                if ((m & ~p) == '0) e[61:60] = 2'd0;
                else e[66 +: NP] = m & ~p;
                q_addr.push_back(IW'(i));
                q_data.push_back(e);
                expt[i] = e;
            end
        end
        @(negedge clk);
        fports = p; fvid = v; fall = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fports = '1; fvid = 12'hFFF; fall = 1'b1;
        check("R1 busy after start", busy == 1'b1, {{(EW-1){1'b0}}, busy}, 1);
        n = 1;
        while (!done && n < 4 * DEPTH) begin
            start = (inject && n == 5);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R9/R10 sweep length", n == 2 * DEPTH + 1, EW'(n), EW'(2 * DEPTH + 1));
        check("R9 busy low at done", !busy, {{(EW-1){1'b0}}, busy}, 0);
        @(negedge clk);
        check("R9 done one cycle", !done, {{(EW-1){1'b0}}, done}, 0);
        repeat (3) begin
            @(negedge clk);
            check("R10 idle after sweep", !busy && !rd_en && !wr_en, {{(EW-1){1'b0}}, busy}, 0);
        end
        check("R7/R8 all predicted writes seen", q_addr.size() == 0, EW'(q_addr.size()), 0);
        for (int i = 0; i < DEPTH; i++)
            check("R2-table contents", mem[i] == expt[i], mem[i], expt[i]);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        mem[0] = mk(2'd1, 12'd5, 1'b0, MC_MAC, 3'b011);   // R7 reduce
        mem[1] = mk(2'd3, 12'd5, 1'b0, MC_MAC, 3'b001);   // R8 free
        mem[2] = mk(2'd1, 12'd7, 1'b0, MC_MAC, 3'b011);   // R3 other VLAN
        mem[3] = mk(2'd1, 12'd5, 1'b1, MC_MAC, 3'b011);   // R4 super
        mem[4] = mk(2'd1, 12'd5, 1'b0, 48'hFFFF_FFFF_FFFF, 3'b111); // R5 broadcast
        mem[5] = mk(2'd1, 12'd5, 1'b0, UC_MAC, 3'b011);   // R2 unicast
        mem[6] = mk(2'd2, 12'd5, 1'b0, MC_MAC, 3'b011);   // R2 VLAN type
        mem[7] = mk(2'd0, 12'd5, 1'b0, MC_MAC, 3'b011);   // R2 free type
        mem[8] = mk(2'd1, 12'd5, 1'b0, MC_MAC, 3'b100);   // R6 no overlap
        mem[DEPTH-1] = mk(2'd3, 12'd9, 1'b0, MC_MAC, 3'b110); // last index
        for (int i = 0; i < DEPTH; i++) expt[i] = mem[i];

        repeat (3) @(negedge clk);
        check("R11 reset outputs", !busy && !done && !rd_en && !wr_en, {{(EW-1){1'b0}}, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", !busy && !done, {{(EW-1){1'b0}}, done}, 0);

        sweep(3'b001, 12'd5, 1'b0, 1'b0);   // R3 filtered sweep
        sweep(3'b010, 12'd0, 1'b1, 1'b1);   // R3 all VLANs, R10 stray start
        sweep(3'b000, 12'd5, 1'b1, 1'b0);   // R6 empty port set
        sweep(3'b110, 12'd9, 1'b0, 1'b0);   // R8 last index freed

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule